// File: doc/BRIEF.md
# Exception Frame Entry and Return Sequencer

This block drives exception entry and exit for a small 32-bit processor core. On an entry request it picks the supervisor stack, rounds that pointer down to a four-byte boundary and writes two longwords below it: the return PC first, then a frame word. The frame word packs the saved status word, the vector offset, a fixed format tag and the two low bits of the stack pointer that were thrown away by the rounding. It then reads the handler address from the vector table and reports the new SR, SP and PC together with a one-cycle done pulse.

On a return request it reads the frame word at the stack pointer and the saved PC just above it. It then rebuilds the exact pre-exception stack pointer, including its unaligned low bits, and restores the status word. Hardware interrupts are filtered against the interrupt mask held in SR. Memory is reached through one 32-bit word port with a request/ready handshake, one access at a time.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset, busy, done and mem_req are low and sr_out, sp_out and pc_out are zero.
- R2: The frame word is laid out as: bits 31:30 = 2'b01, bits 29:28 = low two bits of the selected stack pointer, bits 27:26 = 0, bits 25:16 = vector number times four, bits 15:0 = the SR as presented at the request.
- R3: Entry rounds the selected stack pointer down to a multiple of four (call it A). It writes the return PC at A-4, then the frame word at A-8. Every write address is word aligned, and on completion sp_out = A-8.
- R4: The stack used on entry is sp_in when SR bit 13 (supervisor) is set, and alt_sp_in when it is clear.
- R5: Entry sets SR bit 13 in sr_out. For a hardware interrupt it also puts the request level into SR bits 10:8 and clears SR bit 12. For a software exception the other bits are kept.
- R6: After both pushes, entry performs one read at vbr_in + 4 * vector, and the word read becomes pc_out.
- R7: A hardware interrupt request is acted on only when its level is strictly greater than SR bits 10:8. Otherwise it causes no memory access, no done pulse and no output change.
- R8: Return reads the frame word at sp_in, then the PC at sp_in+4. It then sets sp_out = (sp_in OR frame[29:28]) + 8, sr_out = frame[15:0] and pc_out = the second word read.
- R9: The memory port holds address, write flag and write data steady while a request waits for mem_rdy. done is a single-cycle pulse, raised in the cycle the new SR/SP/PC appear.
- R10: A request presented while busy is high is dropped. It produces no further memory access and no further done pulse.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while not busy |
| req_ret | input | 1 | 1 = return from exception, 0 = entry |
| req_hw | input | 1 | Entry is a hardware interrupt |
| req_level | input | 3 | Pending interrupt level |
| req_vec | input | 8 | Vector number |
| sr_in | input | 16 | Current status word |
| pc_in | input | 32 | Return PC to save |
| sp_in | input | 32 | Active stack pointer |
| alt_sp_in | input | 32 | Supervisor stack pointer when the core is in user mode |
| vbr_in | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sr_out | output | 16 | Updated status word |
| sp_out | output | 32 | Updated stack pointer |
| pc_out | output | 32 | Updated program counter |

## Verification
The bench aims at stack pointers with nonzero low bits. A design that forgets the rounding would push to misaligned addresses, and one that drops the saved bits would return with the stack off by up to three bytes; a full entry-then-return round trip exposes both. Interrupt levels equal to the mask are driven against levels one above it, which catches a greater-or-equal comparison. User-mode entries check that the alternate stack is chosen. Requests pulsed mid-sequence and random ready stalls show whether a design restarts, queues work, or lets its address move before the access completes.

// File: rtl/exc_seq_pkg.sv
// Shared definitions for the exception frame sequencer.
// Assumes a 16-bit status word with fixed bit positions for the
// supervisor, master and interrupt-mask fields.
package exc_seq_pkg;
    localparam int SR_W        = 16;
    localparam int LVL_W       = 3;
    localparam int SR_SUPER    = 13;
    localparam int SR_MASTER   = 12;
    localparam int SR_MASK_LO  = 8;
    localparam logic [1:0] FRM_TAG_HI = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_FRM,
        ST_FETCH_VEC,
        ST_POP_FRM,
        ST_POP_PC
    } seq_state_t;
endpackage

// File: rtl/exc_irq_gate.sv
// Decides whether a request may start an entry sequence.
// Software exceptions always pass; hardware interrupts pass only when
// their level beats the SR mask. Assumes mask at SR bits 10:8.
module exc_irq_gate
    import exc_seq_pkg::*;
#(
    parameter int LVLW = LVL_W
) (
    input  logic            is_hw,
    input  logic [LVLW-1:0] level,
    input  logic [SR_W-1:0] sr,
    output logic            take
);
    logic [LVLW-1:0] cur_mask;

    // Extract mask and compare strictly above it.
    always_comb begin
        cur_mask = sr[SR_MASK_LO +: LVLW];
        take     = !is_hw || (level > cur_mask);
    end
endmodule

// File: rtl/exc_frame_calc.sv
// Combinational frame builder: selects the stack bank, aligns it,
// packs the frame word and forms the post-entry status word.
// Assumes vector offsets fit in frame bits 25:16.
module exc_frame_calc
    import exc_seq_pkg::*;
#(
    parameter int DW   = 32,
    parameter int VECW = 8,
    parameter int LVLW = LVL_W
) (
    input  logic [SR_W-1:0] sr,
    input  logic [DW-1:0]   sp_act,
    input  logic [DW-1:0]   sp_alt,
    input  logic [VECW-1:0] vec,
    input  logic            is_hw,
    input  logic [LVLW-1:0] level,
    output logic [DW-1:0]   sp_aligned,
    output logic [DW-1:0]   frame,
    output logic [SR_W-1:0] sr_entry
);
    localparam int OFFW = VECW + 2;
    localparam int PADW = DW - SR_W - OFFW - 4;

    logic [DW-1:0] sp_sel;

    // Pick the supervisor stack and build the frame word.
    always_comb begin
        sp_sel     = sr[SR_SUPER] ? sp_act : sp_alt;
        sp_aligned = {sp_sel[DW-1:2], 2'b00};
        frame      = {FRM_TAG_HI, sp_sel[1:0], {PADW{1'b0}}, vec, 2'b00, sr};
    end

    // Form the status word that the handler runs under.
    always_comb begin
        sr_entry = sr;
        sr_entry[SR_SUPER] = 1'b1;
        if (is_hw) begin
            sr_entry[SR_MASK_LO +: LVLW] = level;
            sr_entry[SR_MASTER]          = 1'b0;
        end
    end
endmodule

// File: rtl/exc_frame_seq.sv
// Top of the exception entry/return sequencer. Accepts one request
// when idle, runs its memory accesses one at a time over a word port
// with request/ready handshake, and publishes SR/SP/PC with a done
// pulse. Assumes the memory answers every request eventually.
module exc_frame_seq
    import exc_seq_pkg::*;
#(
    parameter int DW   = 32,
    parameter int VECW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_ret,
    input  logic            req_hw,
    input  logic [2:0]      req_level,
    input  logic [VECW-1:0] req_vec,
    input  logic [15:0]     sr_in,
    input  logic [DW-1:0]   pc_in,
    input  logic [DW-1:0]   sp_in,
    input  logic [DW-1:0]   alt_sp_in,
    input  logic [DW-1:0]   vbr_in,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_rdy,
    output logic            busy,
    output logic            done,
    output logic [15:0]     sr_out,
    output logic [DW-1:0]   sp_out,
    output logic [DW-1:0]   pc_out
);
    localparam int VOFFW = VECW + 2;

    seq_state_t      state;
    logic            take;
    logic [DW-1:0]   sp_al_c, frame_c;
    logic [SR_W-1:0] sr_new_c;
    logic [DW-1:0]   sp_al_q, frame_q, pc_q, vaddr_q, rsp_q, rfrm_q;
    logic [SR_W-1:0] sr_new_q;
    logic            ret_q;
    logic            xfer;

    exc_irq_gate #(.LVLW(LVL_W)) u_gate (
        .is_hw (req_hw),
        .level (req_level),
        .sr    (sr_in),
        .take  (take)
    );

    exc_frame_calc #(.DW(DW), .VECW(VECW), .LVLW(LVL_W)) u_calc (
        .sr         (sr_in),
        .sp_act     (sp_in),
        .sp_alt     (alt_sp_in),
        .vec        (req_vec),
        .is_hw      (req_hw),
        .level      (req_level),
        .sp_aligned (sp_al_c),
        .frame      (frame_c),
        .sr_entry   (sr_new_c)
    );

    assign xfer = mem_req && mem_rdy;
    assign busy = (state != ST_IDLE);

    // Drive the memory port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_PC:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_al_q - DW'(4); mem_wdata = pc_q; end
            ST_PUSH_FRM:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_al_q - DW'(8); mem_wdata = frame_q; end
            ST_FETCH_VEC: begin mem_req = 1'b1; mem_addr = vaddr_q; end
            ST_POP_FRM:   begin mem_req = 1'b1; mem_addr = rsp_q; end
            ST_POP_PC:    begin mem_req = 1'b1; mem_addr = rsp_q + DW'(4); end
            default: ;
        endcase
    end

    // Sequence state, captured request and architectural outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            ret_q    <= 1'b0;
            sr_out   <= '0;
            sp_out   <= '0;
            pc_out   <= '0;
            sp_al_q  <= '0;
            frame_q  <= '0;
            pc_q     <= '0;
            vaddr_q  <= '0;
            rsp_q    <= '0;
            rfrm_q   <= '0;
            sr_new_q <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    if (req_ret) begin
                        ret_q <= 1'b1;
                        rsp_q <= sp_in;
                        state <= ST_POP_FRM;
                    end else if (take) begin
                        ret_q    <= 1'b0;
                        sp_al_q  <= sp_al_c;
                        frame_q  <= frame_c;
                        pc_q     <= pc_in;
                        sr_new_q <= sr_new_c;
                        vaddr_q  <= vbr_in + DW'({req_vec, 2'b00});
                        state    <= ST_PUSH_PC;
                    end
                end
                ST_PUSH_PC:  if (xfer) state <= ST_PUSH_FRM;
                ST_PUSH_FRM: if (xfer) state <= ST_FETCH_VEC;
                ST_FETCH_VEC: if (xfer) begin
                    pc_out <= mem_rdata;
                    sp_out <= sp_al_q - DW'(8);
                    sr_out <= sr_new_q;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                ST_POP_FRM: if (xfer) begin
                    rfrm_q <= mem_rdata;
                    state  <= ST_POP_PC;
                end
                ST_POP_PC: if (xfer) begin
                    pc_out <= mem_rdata;
                    sp_out <= (rsp_q | {{(DW-2){1'b0}}, rfrm_q[29:28]}) + DW'(8);
                    sr_out <= rfrm_q[15:0];
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr[1:0] == 2'b00); // R3
    AST_ENTRY_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
        done && !ret_q |-> sr_out[SR_SUPER]); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R10
endmodule

// File: tb/sim_exc_frame_seq.sv
module sim_exc_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_ret = 0, req_hw = 0;
    logic [2:0]  req_level = 0;
    logic [7:0]  req_vec = 0;
    logic [15:0] sr_in = 0;
    logic [31:0] pc_in = 0, sp_in = 0, alt_sp_in = 0, vbr_in = 0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 0;
    logic        mem_rdy = 0;
    logic        busy, done;
    logic [15:0] sr_out;
    logic [31:0] sp_out, pc_out;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [31:0] wr_a [0:7];
    logic [31:0] wr_d [0:7];
    logic [31:0] rd_a [0:7];
    int wn = 0, rn = 0;
    logic [31:0] ret_base = 32'hFFFF_FFF0, ret_frm = 0, ret_pc = 0;

    always #4 clk = ~clk;

    exc_frame_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ret(req_ret),
        .req_hw(req_hw), .req_level(req_level), .req_vec(req_vec),
        .sr_in(sr_in), .pc_in(pc_in), .sp_in(sp_in), .alt_sp_in(alt_sp_in),
        .vbr_in(vbr_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .busy(busy), .done(done), .sr_out(sr_out),
        .sp_out(sp_out), .pc_out(pc_out)
    );

    function automatic logic [31:0] rd_val(input logic [31:0] a);
        if (a == ret_base) return ret_frm;
        if (a == ret_base + 32'd4) return ret_pc;
        return a ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [31:0] exp_frame(input logic [15:0] sr, input logic [31:0] sp, input logic [7:0] v);
        return {2'b01, sp[1:0], 2'b00, v, 2'b00, sr};
    endfunction

    function automatic logic [15:0] exp_sr(input logic [15:0] sr, input logic hw, input logic [2:0] lv);
        logic [15:0] s;
        s = sr | 16'h2000;
        if (hw) begin s[10:8] = lv; s[12] = 1'b0; end
        return s;
    endfunction

    // Memory responder with random ready stalls.
    initial begin
        int wait_n;
        wait_n = 0;
        forever begin
            @(negedge clk);
            mem_rdy = 1'b0;
            if (mem_req) begin
                if (wait_n == 0) begin
                    mem_rdy = 1'b1;
                    if (mem_we) begin
                        if (wn < 8) begin wr_a[wn] = mem_addr; wr_d[wn] = mem_wdata; end
                        wn++;
                    end else begin
                        mem_rdata = rd_val(mem_addr);
                        if (rn < 8) rd_a[rn] = mem_addr;
                        rn++;
                    end
                    wait_n = $urandom_range(0, 2);
                end else wait_n--;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic pulse_req(input bit ret, input bit hw, input logic [2:0] lv, input logic [7:0] v);
        @(negedge clk);
        req_valid = 1; req_ret = ret; req_hw = hw; req_level = lv; req_vec = v;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got, "R9 done seen", {31'b0, got}, 32'd1);
        if (got) begin
            @(negedge clk);
            chk(!done, "R9 done single cycle", {31'b0, done}, 32'd0);
        end
    endtask

    task automatic run_entry(input logic [15:0] sr, input logic [31:0] pc, input logic [31:0] sp,
                             input logic [31:0] alt, input logic [31:0] vbr, input logic [7:0] v,
                             input bit hw, input logic [2:0] lv);
        logic [31:0] sel, al;
        bit got;
        sr_in = sr; pc_in = pc; sp_in = sp; alt_sp_in = alt; vbr_in = vbr;
        wn = 0; rn = 0;
        sel = sr[13] ? sp : alt;
        al = {sel[31:2], 2'b00};
        pulse_req(0, hw, lv, v);
        wait_done(got);
        chk(wn == 2, "R3 two pushes", wn, 2);
        chk(wr_a[0] == al - 4, "R4 R3 pc push addr", wr_a[0], al - 4);
        chk(wr_d[0] == pc, "R3 pc push data", wr_d[0], pc);
        chk(wr_a[1] == al - 8, "R3 frame push addr", wr_a[1], al - 8);
        chk(wr_d[1] == exp_frame(sr, sel, v), "R2 frame word", wr_d[1], exp_frame(sr, sel, v));
        chk(rn == 1 && rd_a[0] == vbr + {22'b0, v, 2'b00}, "R6 vector addr", rd_a[0], vbr + {22'b0, v, 2'b00});
        chk(pc_out == ((vbr + {22'b0, v, 2'b00}) ^ 32'hC0DE_0000), "R6 new pc", pc_out, (vbr + {22'b0, v, 2'b00}) ^ 32'hC0DE_0000);
        chk(sp_out == al - 8, "R3 new sp", sp_out, al - 8);
        chk(sr_out == exp_sr(sr, hw, lv), "R5 new sr", {16'b0, sr_out}, {16'b0, exp_sr(sr, hw, lv)});
    endtask

    task automatic run_return(input logic [31:0] sp, input logic [31:0] frm, input logic [31:0] pc);
        bit got;
        sp_in = sp; ret_base = sp; ret_frm = frm; ret_pc = pc;
        wn = 0; rn = 0;
        pulse_req(1, 0, 0, 0);
        wait_done(got);
        chk(rn == 2 && wn == 0, "R8 two reads only", rn, 2);
        chk(rd_a[0] == sp, "R8 frame read addr", rd_a[0], sp);
        chk(rd_a[1] == sp + 4, "R8 pc read addr", rd_a[1], sp + 4);
        chk(pc_out == pc, "R8 restored pc", pc_out, pc);
        chk(sp_out == (sp | {30'b0, frm[29:28]}) + 8, "R8 restored sp", sp_out, (sp | {30'b0, frm[29:28]}) + 8);
        chk(sr_out == frm[15:0], "R8 restored sr", {16'b0, sr_out}, {16'b0, frm[15:0]});
    endtask

    task automatic run_reject(input logic [15:0] sr, input logic [2:0] lv);
        logic [31:0] p0, s0;
        logic [15:0] r0;
        bit saw_done;
        p0 = pc_out; s0 = sp_out; r0 = sr_out;
        sr_in = sr; wn = 0; rn = 0; saw_done = 0;
        pulse_req(0, 1, lv, 8'h19);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done || busy) saw_done = 1;
        end
        chk(wn == 0 && rn == 0 && !saw_done, "R7 masked irq ignored", wn + rn, 0);
        chk(pc_out == p0 && sp_out == s0 && sr_out == r0, "R7 outputs unchanged", pc_out, p0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] f, p, s;
        bit got;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 reset idle", {busy, done, mem_req}, 0);
        chk(sr_out == 0 && sp_out == 0 && pc_out == 0, "R1 reset outputs", sp_out | pc_out | sr_out, 0);
        rst_n = 1;
        @(negedge clk);

        // Directed: supervisor, unaligned stack, software exception.
        run_entry(16'h2715, 32'h0000_1234, 32'h0000_8003, 32'h0000_4000, 32'h0010_0000, 8'd5, 0, 0);
        // User mode: alternate stack chosen (R4).
        run_entry(16'h0004, 32'h0000_2000, 32'h0000_9000, 32'h0000_A002, 32'h0000_0400, 8'd255, 0, 0);
        // Hardware irq, level just above mask, master bit set.
        run_entry(16'h3300, 32'h0000_3000, 32'h0000_7001, 32'h0, 32'h0, 8'd28, 1, 3'd4);
        // Level equal to mask and level 0 against mask 0 are rejected (R7).
        run_reject(16'h2500, 3'd5);
        run_reject(16'h2000, 3'd0);
        // Round trip: return using the frame just written restores SP exactly.
        run_entry(16'h2011, 32'hDEAD_0000, 32'h0000_6007, 32'h0, 32'h0200_0000, 8'd9, 0, 0);
        f = wr_d[1]; s = sp_out;
        run_return(s, f, 32'hDEAD_0000);
        chk(sp_out == 32'h0000_6007, "R8 round trip sp", sp_out, 32'h0000_6007);

        // Busy hold-off: a request during a sequence is dropped (R10).
        sr_in = 16'h2000; sp_in = 32'h0000_5000; pc_in = 32'h1; vbr_in = 0;
        wn = 0; rn = 0;
        pulse_req(0, 0, 0, 8'd3);
        pulse_req(1, 0, 0, 0);
        wait_done(got);
        for (int i = 0; i < 12; i++) @(negedge clk);
        chk(wn == 2 && rn == 1 && !busy, "R10 request while busy dropped", wn + rn, 3);

        // Random mix.
        for (int k = 0; k < 40; k++) begin
            logic [15:0] sr_r;
            logic [2:0]  lv;
            bit hw;
            sr_r = 16'($urandom());
            hw = 1'($urandom());
            lv = 3'($urandom());
            if (hw && !(lv > sr_r[10:8])) run_reject(sr_r, lv);
            else run_entry(sr_r, $urandom(), $urandom(), $urandom(), {$urandom()} & 32'hFFFF_FF00,
                           8'($urandom()), hw, lv);
            p = $urandom(); f = $urandom(); s = {$urandom()} & 32'hFFFF_FFFC;
            run_return(s, f, p);
        end
        finish_run();
    end
endmodule